// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next level of memory. The processor side hands it word writes, each with a byte address, a data word and a byte-enable mask. Writes are gathered into block-sized entries, up to four of them, and each entry keeps a mask of the bytes it holds. The entries go out to lower memory in the background over a valid/ready port, which carries the block address, the full block of data and the byte mask.

A write whose block is already held in a waiting entry is folded into that entry. The new bytes overwrite the old ones at the same positions and the masks are ORed, so no second slot is used. The entry currently offered on the memory port never takes a merge, which keeps its payload frozen while the handshake is pending. A write to that block takes a fresh slot instead.

When every slot is in use and the incoming write cannot merge, the block raises a stall flag. The processor holds the write until a slot drains. Any write presented while the stall flag is high is not taken.

Top module: `merge_wbuf`

## Requirements
- R1: After reset no entry is held: `memValid` is 0 and `wrFull` is 0.
- R2: A write accepted into a new entry is drained with `memBlockAddr` = `wrAddr[15:4]`. The word is placed at word slot `w = wrAddr[3:2]`. Byte i of `wrData` (bits 8i+7:8i) lands at block byte 4w+i, that is, at `memData` bits 8(4w+i)+7:8(4w+i), and sets `memMask` bit 4w+i when `wrBe[i]` is 1. All other mask bits and data bytes of the new entry are 0.
- R3: An accepted write whose block matches a held entry that is not at the head merges into that entry. Its mask bits are ORed into the entry's mask, its enabled bytes replace the stored bytes, and no extra entry is drained.
- R4: The head entry, which is the one presented on the memory port, never takes a merge. A write to its block while it is held allocates a new entry.
- R5: Entries drain oldest first. One entry leaves on each rising edge where `memValid` and `memReady` are both 1.
- R6: While `memValid` is 1 and `memReady` is 0, `memValid`, `memBlockAddr`, `memData` and `memMask` hold their values into the next cycle.
- R7: `wrFull` is 1 exactly when four entries are held and the presented address has no mergeable entry. A write presented with `wrFull` high is ignored.
- R8: With four entries held, a write to the block of a non-head entry sees `wrFull` at 0, is accepted, and merges.
- R9: A merge into one entry and a drain of the head in the same cycle both take effect.
- R10: `memValid` is 1 whenever at least one entry is held. At most four entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Processor write request |
| wrAddr | input | 16 | Byte address of the written word |
| wrData | input | 32 | Write data word |
| wrBe | input | 4 | Byte enables of the word |
| wrFull | output | 1 | Stall: the write cannot be taken this cycle |
| memValid | output | 1 | Head entry offered to lower memory |
| memReady | input | 1 | Lower memory takes the offered entry |
| memBlockAddr | output | 12 | Block address of the offered entry |
| memData | output | 128 | Block data of the offered entry |
| memMask | output | 16 | Per-byte valid mask of the offered entry |

## Verification
The main function is exercised with several write patterns. A lone full-word write at a non-zero word slot checks placement. Partial writes that overlap and land in different words of a waiting entry tell a true byte-wise merge apart from word replacement and from a fresh allocation. Repeated writes to the block at the head show that the offered entry stays frozen rather than merging. Four distinct blocks bring the buffer to full, and two follow-up writes separate a rejected write from an accepted merge. A merge that coincides with a drain shows that both updates land and that the count stays consistent.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // Strobes from the control to the entry storage
  typedef struct packed {
    logic doAlloc;  // fill slotIdx with the incoming word
    logic doMerge;  // fold the incoming word into slotIdx
    logic doPop;    // head entry taken by lower memory
  } wbufStrobe_t;
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [DEPTH-1:0] matchVec,
  input  logic             memReady,
  output wbufStrobe_t      strobe,
  output logic [IDX_W-1:0] slotIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic             wrFull,
  output logic             memValid
);
  logic [DEPTH-1:0] validQ;
  logic [IDX_W-1:0] headQ, tailQ, hitIdx;
  logic [CNT_W-1:0] countQ;
  logic [DEPTH-1:0] hitVec, headMask;
  logic             mergeHit, accept;

  function automatic logic [IDX_W-1:0] nextPtr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // The head entry is on the memory port and never merges
  assign headMask = DEPTH'(1) << headQ;
  assign hitVec   = matchVec & validQ & ~headMask;
  assign mergeHit = |hitVec;

  always_comb begin
    hitIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign wrFull   = (countQ == CNT_W'(DEPTH)) && !mergeHit;
  assign accept   = wrValid && !wrFull;
  assign memValid = validQ[headQ];

  assign strobe.doAlloc = accept && !mergeHit;
  assign strobe.doMerge = accept && mergeHit;
  assign strobe.doPop   = memValid && memReady;
  assign slotIdx        = mergeHit ? hitIdx : tailQ;
  assign headIdx        = headQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (strobe.doPop) begin
        validQ[headQ] <= 1'b0;
        headQ         <= nextPtr(headQ);
      end
      if (strobe.doAlloc) begin
        validQ[tailQ] <= 1'b1;
        tailQ         <= nextPtr(tailQ);
      end
      countQ <= countQ + CNT_W'(strobe.doAlloc) - CNT_W'(strobe.doPop);
    end
  end
endmodule

// File: rtl/wbuf_data.sv
module wbuf_data
  import wbuf_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 16,
  parameter int WORD_BYTES  = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int WB_W   = $clog2(WORD_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int BLK_W  = BLOCK_BYTES * 8,
  localparam int WORD_W = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbufStrobe_t       strobe,
  input  logic [IDX_W-1:0]  slotIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_BYTES-1:0] wrBe,
  output logic [DEPTH-1:0]  matchVec,
  output logic [TAG_W-1:0]  memBlockAddr,
  output logic [BLK_W-1:0]  memData,
  output logic [BLOCK_BYTES-1:0] memMask
);
  logic [TAG_W-1:0]       tagQ  [DEPTH];
  logic [BLK_W-1:0]       dataQ [DEPTH];
  logic [BLOCK_BYTES-1:0] maskQ [DEPTH];

  logic [TAG_W-1:0]       wrTag;
  logic [OFF_W-WB_W-1:0]  wordSel;
  logic [BLOCK_BYTES-1:0] placeMask;
  logic [BLK_W-1:0]       placeData, placeBits;

  assign wrTag     = wrAddr[ADDR_W-1:OFF_W];
  assign wordSel   = wrAddr[OFF_W-1:WB_W];
  assign placeMask = BLOCK_BYTES'(wrBe) << (int'(wordSel) * WORD_BYTES);
  assign placeData = BLK_W'(wrData) << (int'(wordSel) * WORD_W);

  always_comb begin
    for (int b = 0; b < BLOCK_BYTES; b++) placeBits[b*8 +: 8] = {8{placeMask[b]}};
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign matchVec[g] = (tagQ[g] == wrTag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) begin
        tagQ[e]  <= '0;
        dataQ[e] <= '0;
        maskQ[e] <= '0;
      end
    end else if (strobe.doAlloc) begin
      tagQ[slotIdx]  <= wrTag;
      dataQ[slotIdx] <= placeData;
      maskQ[slotIdx] <= placeMask;
    end else if (strobe.doMerge) begin
      dataQ[slotIdx] <= (dataQ[slotIdx] & ~placeBits) | (placeData & placeBits);
      maskQ[slotIdx] <= maskQ[slotIdx] | placeMask;
    end
  end

  assign memBlockAddr = tagQ[headIdx];
  assign memData      = dataQ[headIdx];
  assign memMask      = maskQ[headIdx];
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import wbuf_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 16,
  parameter int WORD_BYTES  = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int TAG_W  = ADDR_W - $clog2(BLOCK_BYTES),
  localparam int BLK_W  = BLOCK_BYTES * 8,
  localparam int WORD_W = WORD_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrValid,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [WORD_W-1:0]      wrData,
  input  logic [WORD_BYTES-1:0]  wrBe,
  output logic                   wrFull,
  output logic                   memValid,
  input  logic                   memReady,
  output logic [TAG_W-1:0]       memBlockAddr,
  output logic [BLK_W-1:0]       memData,
  output logic [BLOCK_BYTES-1:0] memMask
);
  wbufStrobe_t      strobe;
  logic [IDX_W-1:0] slotIdx, headIdx;
  logic [DEPTH-1:0] matchVec;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .matchVec(matchVec),
    .memReady(memReady), .strobe(strobe), .slotIdx(slotIdx),
    .headIdx(headIdx), .wrFull(wrFull), .memValid(memValid)
  );

  wbuf_data #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx), .headIdx(headIdx),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe), .matchVec(matchVec),
    .memBlockAddr(memBlockAddr), .memData(memData), .memMask(memMask)
  );
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk
  import wbuf_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int TAG_W       = 12,
  parameter int BLOCK_BYTES = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrFull,
  input logic                   memValid,
  input logic                   memReady,
  input logic [TAG_W-1:0]       memBlockAddr,
  input logic [BLOCK_BYTES*8-1:0] memData,
  input logic [BLOCK_BYTES-1:0] memMask,
  input wbufStrobe_t            strobe,
  input logic [IDX_W-1:0]       slotIdx,
  input logic [IDX_W-1:0]       headIdx
);
  int occ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= 0;
    else occ <= occ + int'(strobe.doAlloc) - int'(strobe.doPop);
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !memValid && !wrFull); // R1
  AST_STABLE_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memBlockAddr) && $stable(memData) && $stable(memMask)); // R6
  AST_MERGE_SKIPS_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doMerge |-> slotIdx != headIdx); // R4
  AST_FULL_ALL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    wrFull |-> occ == DEPTH); // R7
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (occ == 0) |-> !memValid); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAlloc |-> occ < DEPTH); // R10
endmodule

bind merge_wbuf merge_wbuf_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrFull(wrFull), .memValid(memValid), .memReady(memReady),
  .memBlockAddr(memBlockAddr), .memData(memData), .memMask(memMask),
  .strobe(strobe), .slotIdx(slotIdx), .headIdx(headIdx)
);

// File: tb/sim_merge_wbuf.sv
module sim_merge_wbuf;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrValid = 1'b0;
  logic [15:0]  wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic [3:0]   wrBe = '0;
  logic         wrFull, memValid;
  logic         memReady = 1'b0;
  logic [11:0]  memBlockAddr;
  logic [127:0] memData;
  logic [15:0]  memMask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [11:0] addr; logic [127:0] data; logic [15:0] mask; } item_t;
  item_t expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  merge_wbuf u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrBe(wrBe), .wrFull(wrFull), .memValid(memValid), .memReady(memReady),
    .memBlockAddr(memBlockAddr), .memData(memData), .memMask(memMask)
  );

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic expectDrain(input logic [11:0] a, input logic [127:0] d,
                             input logic [15:0] m, input string tag);
    item_t it;
    it.addr = a; it.data = d; it.mask = m;
    expQ.push_back(it);
    tagQ.push_back(tag);
  endtask

  task automatic writeWord(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d; wrBe = be;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic drainAll();
    @(negedge clk);
    memReady = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!memValid) break;
    end
    memReady = 1'b0;
  endtask

  // Monitor: every handshake pops the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && memValid && memReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, $sformatf("R5 unexpected drain addr=%h expected none", memBlockAddr));
        end else begin
          item_t e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(memBlockAddr == e.addr && memData == e.data && memMask == e.mask,
              $sformatf("%s drain addr=%h data=%h mask=%h expected addr=%h data=%h mask=%h",
                        t, memBlockAddr, memData, memMask, e.addr, e.data, e.mask));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0]  holdA;
    logic [127:0] holdD;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!memValid && !wrFull, $sformatf("R1 after reset memValid=%0b wrFull=%0b expected 0 0", memValid, wrFull));

    // R2: single word at word slot 1
    writeWord(16'h0124, 32'hAABBCCDD, 4'hF);
    #1;
    chk(memValid, $sformatf("R10 held entry memValid=%0b expected 1", memValid));
    expectDrain(12'h012, 128'h00000000_00000000_AABBCCDD_00000000, 16'h00F0, "R2");
    drainAll();
    #1;
    chk(!memValid, $sformatf("R10 empty memValid=%0b expected 0", memValid));

    // R3/R5/R6: merge into a non-head entry, oldest first
    writeWord(16'h1000, 32'h12345678, 4'hF);
    writeWord(16'h2000, 32'h00001111, 4'b0011);
    writeWord(16'h2000, 32'h00222200, 4'b0110);
    writeWord(16'h200C, 32'h33000000, 4'b1000);
    #1;
    holdA = memBlockAddr; holdD = memData;
    repeat (3) @(negedge clk);
    #1;
    chk(memValid && memBlockAddr == holdA && memData == holdD && holdA == 12'h100,
        $sformatf("R6 stalled offer addr=%h expected %h (first %h)", memBlockAddr, holdA, 12'h100));
    expectDrain(12'h100, 128'h12345678, 16'h000F, "R5");
    expectDrain(12'h200, 128'h33000000_00000000_00000000_00222211, 16'h8007, "R3");
    drainAll();
    #1;
    chk(!memValid && expQ.size() == 0,
        $sformatf("R3 leftover entries memValid=%0b pending=%0d expected 0 0", memValid, expQ.size()));

    // R4: head does not merge
    writeWord(16'h3000, 32'h00000001, 4'hF);
    writeWord(16'h3000, 32'h00000002, 4'b0001);
    expectDrain(12'h300, 128'h1, 16'h000F, "R4");
    expectDrain(12'h300, 128'h2, 16'h0001, "R4");
    drainAll();

    // R7/R8: full, reject and merge
    for (int i = 0; i < 4; i++) writeWord(16'h4000 + 16'(i * 16), 32'h40000000 + i, 4'hF);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = 16'h5000; wrData = 32'hDEADBEEF; wrBe = 4'hF;
    #1;
    chk(wrFull, $sformatf("R7 wrFull=%0b expected 1", wrFull));
    @(negedge clk);
    #1;
    chk(wrFull, $sformatf("R7 held wrFull=%0b expected 1", wrFull));
    wrAddr = 16'h4028; wrData = 32'hCAFEF00D;
    #1;
    chk(!wrFull, $sformatf("R8 mergeable wrFull=%0b expected 0", wrFull));
    @(negedge clk);
    wrValid = 1'b0;
    expectDrain(12'h400, 128'h40000000, 16'h000F, "R7");
    expectDrain(12'h401, 128'h40000001, 16'h000F, "R7");
    expectDrain(12'h402, 128'h00000000_CAFEF00D_00000000_40000002, 16'h0F0F, "R8");
    expectDrain(12'h403, 128'h40000003, 16'h000F, "R7");
    drainAll();
    #1;
    chk(!memValid && expQ.size() == 0,
        $sformatf("R7 rejected write drained: pending=%0d memValid=%0b expected 0 0", expQ.size(), memValid));

    // R9: merge and drain in the same cycle
    writeWord(16'h6000, 32'h00000060, 4'b0001);
    writeWord(16'h6010, 32'h00000061, 4'b0001);
    expectDrain(12'h600, 128'h60, 16'h0001, "R9");
    expectDrain(12'h601, 128'h00000000_00000000_00007700_00000061, 16'h0021, "R9");
    @(negedge clk);
    memReady = 1'b1;
    wrValid = 1'b1; wrAddr = 16'h6014; wrData = 32'h00007700; wrBe = 4'b0010;
    @(negedge clk);
    wrValid = 1'b0;
    memReady = 1'b0;
    #1;
    chk(memValid && memBlockAddr == 12'h601,
        $sformatf("R9 after concurrent cycle addr=%h valid=%0b expected 601 1", memBlockAddr, memValid));
    drainAll();
    #1;
    chk(!memValid, $sformatf("R9 count memValid=%0b expected 0", memValid));
    chk(expQ.size() == 0, $sformatf("R5 pending drains=%0d expected 0", expQ.size()));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule